// File: doc/BRIEF.md
# Torus Neighbour Route Selector

This block works out, for a node of a three-dimensional wrap-around array, how a remote-memory access reaches its partner. All nodes use one shared relative displacement. The block reduces each axis component modulo that axis's ring length. On every axis it picks the shorter way around the ring, and it reports a hop count, a direction and a link enable. Axes with a nonzero remainder get their own link, so a diagonal displacement drives several axis paths at once.

The same block also describes broadcasts. A broadcast can reach the whole machine, a line of nodes along one chosen axis, or a plane of nodes that lies normal to a chosen axis. For each axis it gives a membership mask of receiving coordinates. The block has no way to give each node its own displacement, so that request code and all other undefined codes are flagged as unsupported.

A request strobe captures the inputs. The results appear on registered outputs one cycle later and stay there until the next strobe.

Top module: `nc_router`

## Requirements
- R1: A result is presented with out_valid high exactly in the cycle after req is sampled high, and out_valid is low otherwise. Synchronous active-high reset clears every output to zero.
- R2: Between strobes every result output holds its last value, whatever the other inputs do.
- R3: In point-to-point mode (mode code 0), each axis takes its displacement as two's complement in the range -16..15. That value is reduced modulo the ring size, and out_dest for the axis equals (coordinate + displacement) mod size.
- R4: For a reduced displacement m on ring size S, the hop count is the smaller of m and S-m. The direction bit is 0 (positive) when m <= S-m, so a tie goes positive, and 1 otherwise. A link enable is high only when its hop count is nonzero, and this holds on every axis independently.
- R5: In point-to-point mode, when every axis reduces to zero, out_local is high and no link is enabled.
- R6: In point-to-point mode each axis mask is one-hot at the destination coordinate. Axis a occupies mask bits [16a+15:16a], and bit index equals coordinate.
- R7: Full broadcast (mode code 1) sets mask bits 0..S-1 on every axis. It enables the link of each axis with S > 1, reports hop count floor(S/2) with direction 0, and returns the node's own coordinates as destination.
- R8: Line broadcast (mode code 2) spans only the axis named by sel_axis (0=x, 1=y, 2=z). The other axes carry a one-hot mask at the node's own coordinate, with zero hops and no link.
- R9: Plane broadcast (mode code 3) keeps the axis named by sel_axis fixed at the node's own coordinate and spans the other two axes.
- R10: Mode code 4 (per-node displacement), codes 5..7, and line or plane with sel_axis 3 raise out_unsup. In that case all links, hops, directions, destinations and masks are zero and out_local is low.
- R11: A ring size of 1 never enables its link and always reduces to zero. Any displacement on such an axis is local.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, captures all inputs |
| mode | input | 3 | Route mode code |
| sel_axis | input | 2 | Line axis or plane normal |
| node_pos | input | 12 | Own coordinates, axis a at [4a+3:4a] |
| ring_size | input | 15 | Ring length per axis 1..16, axis a at [5a+4:5a] |
| disp | input | 15 | Signed displacement per axis, axis a at [5a+4:5a] |
| out_valid | output | 1 | Result strobe |
| out_local | output | 1 | Access stays on this node |
| out_unsup | output | 1 | Request mode not supported |
| out_dir | output | 3 | Per-axis direction, 1 = negative |
| out_link | output | 3 | Per-axis link enable |
| out_hops | output | 12 | Per-axis hop count |
| out_dest | output | 12 | Per-axis destination coordinate |
| out_mask | output | 48 | Per-axis receiving-coordinate mask |

## Verification
The bench builds the block with its default four-bit coordinates. Ring lengths therefore run from 1 to 16 and displacements from -16 to 15. At those values a displacement can wrap more than once or equal a whole ring length. An even ring can produce an exact half-way tie, and a one-node ring must never light its link. Broadcast masks reach the full 16-bit width on the largest ring, so the top mask bit and the mode and axis codes without a defined meaning are all exercised.

// File: rtl/nc_pkg.sv
package nc_pkg;

    localparam int NUM_AXES = 3;
    localparam int COORD_W  = 4;
    localparam int SIZE_W   = COORD_W + 1;
    localparam int RING_MAX = 1 << COORD_W;

    typedef enum logic [2:0] {
        RM_POINT    = 3'd0,
        RM_ALL      = 3'd1,
        RM_LINE     = 3'd2,
        RM_PLANE    = 3'd3,
        RM_PER_NODE = 3'd4
    } route_mode_e;

    typedef struct packed {
        logic [NUM_AXES-1:0] span;
        logic                bcast;
        logic                p2p;
        logic                unsup;
    } route_ctl_t;

    // non-negative remainder of v modulo n (n >= 1)
    function automatic int ring_mod(input int v, input int n);
        int r;
        r = v % n;
        if (r < 0) r = r + n;
        return r;
    endfunction

endpackage

// File: rtl/nc_mode_decode.sv
module nc_mode_decode
    import nc_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] sel_axis,
    output route_ctl_t ctl
);
    localparam int NAX = NUM_AXES;

    logic sel_ok;
    assign sel_ok = int'(sel_axis) < NAX;

    always_comb begin
        ctl = '0;
        case (route_mode_e'(mode))
            RM_POINT: ctl.p2p = 1'b1;
            RM_ALL: begin
                ctl.bcast = 1'b1;
                ctl.span  = '1;
            end
            RM_LINE: begin
                if (sel_ok) begin
                    ctl.bcast = 1'b1;
                    ctl.span  = NAX'(1) << sel_axis;
                end else begin
                    ctl.unsup = 1'b1;
                end
            end
            RM_PLANE: begin
                if (sel_ok) begin
                    ctl.bcast = 1'b1;
                    ctl.span  = ~(NAX'(1) << sel_axis);
                end else begin
                    ctl.unsup = 1'b1;
                end
            end
            default: ctl.unsup = 1'b1;
        endcase
    end
endmodule

// File: rtl/nc_axis_path.sv
module nc_axis_path
    import nc_pkg::*;
#(
    parameter int CW = COORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            bcast,
    input  logic            span,
    input  logic [CW-1:0]   pos,
    input  logic [CW:0]     size,
    input  logic [CW:0]     disp,
    output logic            dir,
    output logic            link,
    output logic            zero,
    output logic [CW-1:0]   hops,
    output logic [CW-1:0]   dest,
    output logic [(1<<CW)-1:0] mask
);
    localparam int NRING = 1 << CW;

    int eff;
    int m;
    int back;
    int dpos;

    always_comb begin
        eff  = (size == '0) ? 1 : int'(size);
        m    = ring_mod(int'($signed(disp)), eff);
        back = eff - m;
        zero = (m == 0);
        dir  = 1'b0;
        link = 1'b0;
        hops = '0;
        dest = '0;
        mask = '0;
        dpos = 0;
        if (active) begin
            if (bcast) begin
                dpos = ring_mod(int'(pos), eff);
                if (span && eff > 1) begin
                    hops = CW'(eff / 2);
                    link = 1'b1;
                end
            end else begin
                dpos = ring_mod(int'(pos) + m, eff);
                if (m != 0) begin
                    if (m <= back) begin
                        hops = CW'(m);
                    end else begin
                        hops = CW'(back);
                        dir  = 1'b1;
                    end
                    link = 1'b1;
                end
            end
            dest = CW'(dpos);
            for (int i = 0; i < NRING; i++) begin
                mask[i] = (bcast && span) ? (i < eff) : (i == dpos);
            end
        end
    end

    p_dest_in_ring_r3: assert property (@(posedge clk) disable iff (rst)
        active |-> (int'(dest) < eff));

    p_shortest_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (active && !bcast) |-> (int'(hops) * 2 <= eff));

endmodule

// File: rtl/nc_router.sv
module nc_router
    import nc_pkg::*;
#(
    parameter int NAX = NUM_AXES,
    parameter int CW  = COORD_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req,
    input  logic [2:0]                mode,
    input  logic [1:0]                sel_axis,
    input  logic [NAX*CW-1:0]         node_pos,
    input  logic [NAX*(CW+1)-1:0]     ring_size,
    input  logic [NAX*(CW+1)-1:0]     disp,
    output logic                      out_valid,
    output logic                      out_local,
    output logic                      out_unsup,
    output logic [NAX-1:0]            out_dir,
    output logic [NAX-1:0]            out_link,
    output logic [NAX*CW-1:0]         out_hops,
    output logic [NAX*CW-1:0]         out_dest,
    output logic [NAX*(1<<CW)-1:0]    out_mask
);
    localparam int SW = CW + 1;
    localparam int MW = 1 << CW;

    route_ctl_t ctl;

    logic [NAX-1:0]      ax_dir;
    logic [NAX-1:0]      ax_link;
    logic [NAX-1:0]      ax_zero;
    logic [NAX*CW-1:0]   ax_hops;
    logic [NAX*CW-1:0]   ax_dest;
    logic [NAX*MW-1:0]   ax_mask;

    nc_mode_decode u_dec (
        .mode     (mode),
        .sel_axis (sel_axis),
        .ctl      (ctl)
    );

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        nc_axis_path #(.CW(CW)) u_path (
            .clk    (clk),
            .rst    (rst),
            .active (!ctl.unsup),
            .bcast  (ctl.bcast),
            .span   (ctl.span[a]),
            .pos    (node_pos[a*CW +: CW]),
            .size   (ring_size[a*SW +: SW]),
            .disp   (disp[a*SW +: SW]),
            .dir    (ax_dir[a]),
            .link   (ax_link[a]),
            .zero   (ax_zero[a]),
            .hops   (ax_hops[a*CW +: CW]),
            .dest   (ax_dest[a*CW +: CW]),
            .mask   (ax_mask[a*MW +: MW])
        );

        p_link_needs_hops_r4: assert property (@(posedge clk) disable iff (rst)
            out_link[a] |-> (out_hops[a*CW +: CW] != '0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_local <= 1'b0;
            out_unsup <= 1'b0;
            out_dir   <= '0;
            out_link  <= '0;
            out_hops  <= '0;
            out_dest  <= '0;
            out_mask  <= '0;
        end else begin
            out_valid <= req;
            if (req) begin
                out_local <= ctl.p2p && (&ax_zero);
                out_unsup <= ctl.unsup;
                out_dir   <= ax_dir;
                out_link  <= ax_link;
                out_hops  <= ax_hops;
                out_dest  <= ax_dest;
                out_mask  <= ax_mask;
            end
        end
    end

    p_valid_after_req_r1: assert property (@(posedge clk) disable iff (rst)
        req |=> out_valid);

    p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (rst)
        !req |=> !out_valid);

    p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
        !req |=> ($stable(out_dest) && $stable(out_mask) && $stable(out_link)));

    p_local_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        out_local |-> (out_link == '0));

    p_unsup_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        out_unsup |-> (out_link == '0 && out_mask == '0 && !out_local));

endmodule

// File: tb/nc_router_test.sv
`timescale 1ns/1ps
module nc_router_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  sel_axis = '0;
    logic [11:0] node_pos = '0;
    logic [14:0] ring_size = '0;
    logic [14:0] disp = '0;
    logic        out_valid, out_local, out_unsup;
    logic [2:0]  out_dir, out_link;
    logic [11:0] out_hops, out_dest;
    logic [47:0] out_mask;

    always #10 clk = ~clk;

    nc_router uut (
        .clk(clk), .rst(rst), .req(req), .mode(mode), .sel_axis(sel_axis),
        .node_pos(node_pos), .ring_size(ring_size), .disp(disp),
        .out_valid(out_valid), .out_local(out_local), .out_unsup(out_unsup),
        .out_dir(out_dir), .out_link(out_link), .out_hops(out_hops),
        .out_dest(out_dest), .out_mask(out_mask)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int px[3], sz[3], dv[3];
    int e_dir[3], e_link[3], e_hops[3], e_dest[3], e_mask[3];
    int e_local, e_unsup;

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input int md, input int sl);
        bit p2p, bc, un, all_zero;
        bit sp[3];
        p2p = 0; bc = 0; un = 0; all_zero = 1;
        for (int a = 0; a < 3; a++) sp[a] = 0;
        if (md == 0) p2p = 1;
        else if (md == 1) begin bc = 1; for (int a = 0; a < 3; a++) sp[a] = 1; end
        else if (md == 2 && sl < 3) begin bc = 1; sp[sl] = 1; end
        else if (md == 3 && sl < 3) begin bc = 1; for (int a = 0; a < 3; a++) sp[a] = (a != sl); end
        else un = 1;
        for (int a = 0; a < 3; a++) begin
            int s, c, k, f;
            s = (sz[a] == 0) ? 1 : sz[a];
            e_dir[a] = 0; e_link[a] = 0; e_hops[a] = 0; e_dest[a] = 0; e_mask[a] = 0;
            if (un) continue;
            if (p2p) begin
                c = px[a]; k = dv[a];
                while (k > 0) begin c = (c + 1 == s) ? 0 : c + 1; k--; end
                while (k < 0) begin c = (c == 0) ? s - 1 : c - 1; k++; end
                f = 0; k = px[a];
                while (k != c) begin k = (k + 1 == s) ? 0 : k + 1; f++; end
                if (f != 0) begin
                    all_zero = 0;
                    e_link[a] = 1;
                    if (f <= s - f) e_hops[a] = f;
                    else begin e_hops[a] = s - f; e_dir[a] = 1; end
                end
                e_dest[a] = c;
                e_mask[a] = 1 << c;
            end else begin
                e_dest[a] = px[a];
                if (sp[a]) begin
                    e_mask[a] = (1 << s) - 1;
                    e_hops[a] = (s > 1) ? s / 2 : 0;
                    e_link[a] = (s > 1) ? 1 : 0;
                end else begin
                    e_mask[a] = 1 << px[a];
                end
            end
        end
        e_local = (p2p && all_zero) ? 1 : 0;
        e_unsup = un ? 1 : 0;
    endtask

    task automatic apply(input int md, input int sl);
        @(negedge clk);
        mode = 3'(md);
        sel_axis = 2'(sl);
        for (int a = 0; a < 3; a++) begin
            node_pos[a*4 +: 4]  = 4'(px[a]);
            ring_size[a*5 +: 5] = 5'(sz[a]);
            disp[a*5 +: 5]      = 5'(dv[a]);
        end
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        model(md, sl);
    endtask

    task automatic check_out(string tag);
        chk({tag, " valid (R1)"}, int'(out_valid), 1);
        chk({tag, " local"}, int'(out_local), e_local);
        chk({tag, " unsup"}, int'(out_unsup), e_unsup);
        for (int a = 0; a < 3; a++) begin
            chk($sformatf("%s hops ax%0d", tag, a), int'(out_hops[a*4 +: 4]), e_hops[a]);
            chk($sformatf("%s dir ax%0d", tag, a), int'(out_dir[a]), e_dir[a]);
            chk($sformatf("%s link ax%0d", tag, a), int'(out_link[a]), e_link[a]);
            chk($sformatf("%s dest ax%0d", tag, a), int'(out_dest[a*4 +: 4]), e_dest[a]);
            chk($sformatf("%s mask ax%0d", tag, a), int'(out_mask[a*16 +: 16]), e_mask[a]);
        end
    endtask

    task automatic set3(input int p0, p1, p2, s0, s1, s2, d0, d1, d2);
        px[0] = p0; px[1] = p1; px[2] = p2;
        sz[0] = s0; sz[1] = s1; sz[2] = s2;
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
    endtask

    task automatic t_reset;
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset link", int'(out_link), 0);
        chk("R1 reset hops", int'(out_hops), 0);
        chk("R1 reset mask lo", int'(out_mask[31:0]), 0);
        chk("R1 reset mask hi", int'(out_mask[47:32]), 0);
        chk("R1 reset flags", int'({out_local, out_unsup}), 0);
    endtask

    task automatic t_point;
        set3(1, 2, 3, 8, 8, 8, 2, -3, 0);
        apply(0, 0);
        check_out("R3 R4 R6 point");
        set3(5, 0, 7, 9, 7, 10, 6, 4, -9);
        apply(0, 0);
        check_out("R4 R6 multi-axis negative");
    endtask

    task automatic t_wrap;
        set3(14, 4, 0, 16, 5, 6, 15, -16, 3);
        apply(0, 0);
        check_out("R3 R4 wrap and tie");
        set3(15, 3, 2, 16, 12, 4, -16, 6, 2);
        apply(0, 0);
        check_out("R4 even ring half-way");
    endtask

    task automatic t_local;
        set3(3, 6, 1, 8, 8, 5, 8, -8, -15);
        apply(0, 0);
        check_out("R5 multiple of ring");
        chk("R5 local flag", int'(out_local), 1);
        set3(2, 2, 2, 4, 4, 4, 0, 0, 0);
        apply(0, 0);
        check_out("R5 zero displacement");
    endtask

    task automatic t_hold;
        set3(1, 1, 1, 6, 6, 6, 2, -1, 3);
        apply(0, 0);
        check_out("R2 setup");
        @(negedge clk);
        mode = 3'd1;
        disp = 15'h1234;
        node_pos = 12'hABC;
        repeat (3) @(negedge clk);
        chk("R1 valid drops", int'(out_valid), 0);
        chk("R2 hold dest", int'(out_dest), int'({4'(e_dest[2]), 4'(e_dest[1]), 4'(e_dest[0])}));
        chk("R2 hold link", int'(out_link), int'({1'(e_link[2]), 1'(e_link[1]), 1'(e_link[0])}));
        chk("R2 hold mask x", int'(out_mask[15:0]), e_mask[0]);
    endtask

    task automatic t_bcast;
        set3(3, 0, 15, 5, 2, 16, 7, 7, 7);
        apply(1, 0);
        check_out("R7 full broadcast");
        chk("R7 full mask z", int'(out_mask[47:32]), 16'hFFFF);
        set3(2, 5, 1, 4, 6, 3, 1, 1, 1);
        apply(2, 1);
        check_out("R8 line along y");
        apply(2, 2);
        check_out("R8 line along z");
        apply(3, 0);
        check_out("R9 plane normal x");
        apply(3, 2);
        check_out("R9 plane normal z");
    endtask

    task automatic t_unsup;
        set3(1, 2, 3, 8, 8, 8, 3, 3, 3);
        apply(4, 0);
        check_out("R10 per-node mode");
        apply(7, 0);
        check_out("R10 reserved code");
        apply(2, 3);
        check_out("R10 line bad axis");
        apply(3, 3);
        check_out("R10 plane bad axis");
    endtask

    task automatic t_size_one;
        set3(0, 0, 4, 1, 1, 9, 5, -7, 0);
        apply(0, 0);
        check_out("R11 unit rings");
        chk("R11 no links", int'(out_link), 0);
        set3(0, 3, 0, 1, 7, 1, 9, 2, -3);
        apply(0, 0);
        check_out("R11 unit ring with active axis");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_point();
        t_wrap();
        t_local();
        t_hold();
        t_bcast();
        t_unsup();
        t_size_one();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule